// File: doc/BRIEF.md
# Overcurrent Alarm Monitor

The monitor watches one asynchronous overcurrent alarm pin from outside the chip. It brings the pin into the clock domain and turns it into a throttle request for the clock-rate limiter next to it. It also counts alarm episodes so that software is interrupted only when episodes pile up. The pin's active level is set in configuration. Each transition from inactive to active is one event. An interrupt is raised when the running event count reaches a programmed threshold, and it stays raised until software clears it.

An inactivity window, counted in clocks, keeps isolated glitches from adding up. If that many clocks pass with no new event, the count falls back to zero and the window starts again. The throttle request follows the synchronized alarm level. After the alarm goes away the request can be stretched by a hold time given in microseconds. The hold is converted to clocks using a programmed number of clocks per microsecond.

All configuration inputs are expected to stay steady while the block is in use. Change them only with the block idle or in reset.

Top module: `ocAlarmMonitor`

## Requirements
- R1: When cfgActiveLow is 1, a low level on alarmPin is the alarm and a high level is idle. When cfgActiveLow is 0, a high level is the alarm.
- R2: throttleReq goes high after the third rising clock edge following the pin entering its active level, and stays high while the pin remains active.
- R3: With cfgHoldUs equal to 0, throttleReq falls after the third rising edge following the pin leaving its active level. With a nonzero hold it falls cfgHoldUs × cfgClocksPerUs clocks later than that. A cfgClocksPerUs of 0 behaves as 1.
- R4: Only an inactive-to-active transition counts as an event. An alarm level held for any length of time counts once.
- R5: When cfgIrqEnable is 1 and an event brings the count to a value at or above cfgCountThreshold, irqOut goes high after the third rising edge following the pin change that caused the event.
- R6: A cfgCountThreshold of 0 makes every event raise the interrupt while cfgIrqEnable is 1.
- R7: While cfgIrqEnable is 0, irqOut never rises, whatever the events and the threshold.
- R8: When cfgFilterClocks is F and F is not 0, an event that comes more than F clocks after the previous counted event finds the count already cleared and counts as the first. An event that comes F or fewer clocks after the previous one adds to the count. When F is 0 the count is never cleared.
- R9: irqOut stays high until a clock edge at which irqClear is 1. If a new interrupt condition arrives at that same edge, the interrupt condition wins and irqOut stays high.
- R10: After reset, irqOut and throttleReq are 0 and the event count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| alarmPin | input | 1 | Raw overcurrent alarm from outside the chip |
| cfgActiveLow | input | 1 | 1: alarm is a low level; 0: alarm is a high level |
| cfgIrqEnable | input | 1 | Allows the count threshold to raise the interrupt |
| cfgCountThreshold | input | COUNT_W | Event count at which the interrupt is raised |
| cfgFilterClocks | input | FILTER_W | Inactivity window in clocks; 0 disables clearing |
| cfgHoldUs | input | HOLD_W | Throttle hold after the alarm ends, in microseconds |
| cfgClocksPerUs | input | CLKUS_W | Clocks per microsecond for the hold conversion |
| irqClear | input | 1 | Write-one-to-clear strobe for the interrupt |
| throttleReq | output | 1 | Throttle request to the clock limiter |
| irqOut | output | 1 | Sticky interrupt |

## Verification
The hardest case to reach from the ports is an event that lands exactly on the edge where the inactivity window would expire. There the event must win, and the count must carry on instead of restarting. The bench places pulses with gaps of F-1, F and F+1 clocks. Each gap is measured between the cycles in which the pin is driven active, and the two-flop path adds the same delay to both pulses. A second hard case is an interrupt clear that arrives on the very edge where a new event raises the interrupt again. The bench lines up the clear strobe with the third edge after a pin transition, so that both act on the same edge.

// File: rtl/ocAlarmPkg.sv
package ocAlarmPkg;

  // Strobes from control to datapath, one clock wide each.
  typedef struct packed {
    logic countInc;    // a new alarm event this cycle
    logic countClear;  // inactivity window expired, drop the count
    logic holdLoad;    // alarm active: reload the hold timer
    logic holdStep;    // alarm fully gone: advance the hold timer
  } dpStrobes_t;

  // Status returned from datapath to control.
  typedef struct packed {
    logic countReached;  // count after this event meets the threshold
    logic filterDue;     // this clock closes the inactivity window
    logic holdBusy;      // hold time still running
  } dpStatus_t;

endpackage

// File: rtl/ocAlarmCtrl.sv
module ocAlarmCtrl
  import ocAlarmPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       alarmPin,
  input  logic       cfgActiveLow,
  input  logic       cfgIrqEnable,
  input  logic       irqClear,
  input  dpStatus_t  status,
  output dpStrobes_t strobes,
  output logic       throttleReq,
  output logic       irqOut
);

  // The polarity is folded in ahead of the first flop, so reset gives "inactive".
  logic syncStage1, syncStage2, activePrev;
  logic eventPulse, irqSet, irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage1 <= 1'b0;
      syncStage2 <= 1'b0;
      activePrev <= 1'b0;
    end else begin
      syncStage1 <= alarmPin ^ cfgActiveLow;
      syncStage2 <= syncStage1;
      activePrev <= syncStage2;
    end
  end

  assign eventPulse = syncStage2 & ~activePrev;

  always_comb begin
    strobes.countInc   = eventPulse;
    strobes.countClear = status.filterDue & ~eventPulse;
    strobes.holdLoad   = syncStage2;
    strobes.holdStep   = ~syncStage2 & ~activePrev & status.holdBusy;
  end

  assign irqSet = eventPulse & cfgIrqEnable & status.countReached;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         irqQ <= 1'b0;
    else if (irqSet)   irqQ <= 1'b1;
    else if (irqClear) irqQ <= 1'b0;
  end

  assign irqOut      = irqQ;
  assign throttleReq = activePrev | status.holdBusy;

endmodule

// File: rtl/ocAlarmDatapath.sv
module ocAlarmDatapath
  import ocAlarmPkg::*;
#(
  parameter int COUNT_W  = 8,
  parameter int FILTER_W = 16,
  parameter int HOLD_W   = 8,
  parameter int CLKUS_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobes_t          strobes,
  input  logic [COUNT_W-1:0]  cfgCountThreshold,
  input  logic [FILTER_W-1:0] cfgFilterClocks,
  input  logic [HOLD_W-1:0]   cfgHoldUs,
  input  logic [CLKUS_W-1:0]  cfgClocksPerUs,
  output dpStatus_t           status,
  output logic [COUNT_W-1:0]  countValue
);

  localparam logic [COUNT_W-1:0] COUNT_MAX = {COUNT_W{1'b1}};
  localparam logic [FILTER_W-1:0] FILTER_ONE = FILTER_W'(1);
  localparam logic [CLKUS_W-1:0] TICK_ONE = CLKUS_W'(1);

  logic [COUNT_W-1:0]  eventCount, countBumped;
  logic [FILTER_W-1:0] idleTimer;
  logic [HOLD_W-1:0]   usLeft;
  logic [CLKUS_W-1:0]  tickLeft;
  logic                tickLast;

  // The count saturates instead of wrapping, so a long burst never drops the interrupt.
  assign countBumped = (eventCount == COUNT_MAX) ? eventCount : eventCount + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventCount <= '0;
      idleTimer  <= '0;
    end else if (strobes.countInc) begin
      eventCount <= countBumped;
      idleTimer  <= '0;
    end else if (strobes.countClear) begin
      eventCount <= '0;
      idleTimer  <= '0;
    end else if (eventCount != '0) begin
      idleTimer  <= idleTimer + 1'b1;
    end
  end

  // Two-level hold timer: microseconds outside, clocks per microsecond inside.
  assign tickLast = (tickLeft <= TICK_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usLeft   <= '0;
      tickLeft <= '0;
    end else if (strobes.holdLoad) begin
      usLeft   <= cfgHoldUs;
      tickLeft <= cfgClocksPerUs;
    end else if (strobes.holdStep) begin
      if (tickLast) begin
        tickLeft <= cfgClocksPerUs;
        usLeft   <= usLeft - 1'b1;
      end else begin
        tickLeft <= tickLeft - 1'b1;
      end
    end
  end

  always_comb begin
    status.countReached = (countBumped >= cfgCountThreshold);
    status.filterDue    = (cfgFilterClocks != '0) && (eventCount != '0) &&
                          (idleTimer == cfgFilterClocks - FILTER_ONE);
    status.holdBusy     = (usLeft != '0);
  end

  assign countValue = eventCount;

endmodule

// File: rtl/ocAlarmMonitor.sv
module ocAlarmMonitor
  import ocAlarmPkg::*;
#(
  parameter int COUNT_W  = 8,
  parameter int FILTER_W = 16,
  parameter int HOLD_W   = 8,
  parameter int CLKUS_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                alarmPin,
  input  logic                cfgActiveLow,
  input  logic                cfgIrqEnable,
  input  logic [COUNT_W-1:0]  cfgCountThreshold,
  input  logic [FILTER_W-1:0] cfgFilterClocks,
  input  logic [HOLD_W-1:0]   cfgHoldUs,
  input  logic [CLKUS_W-1:0]  cfgClocksPerUs,
  input  logic                irqClear,
  output logic                throttleReq,
  output logic                irqOut
);

  dpStrobes_t         strobes;
  dpStatus_t          status;
  logic [COUNT_W-1:0] countValue;

  ocAlarmCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .alarmPin(alarmPin),
    .cfgActiveLow(cfgActiveLow), .cfgIrqEnable(cfgIrqEnable),
    .irqClear(irqClear), .status(status), .strobes(strobes),
    .throttleReq(throttleReq), .irqOut(irqOut)
  );

  ocAlarmDatapath #(
    .COUNT_W(COUNT_W), .FILTER_W(FILTER_W), .HOLD_W(HOLD_W), .CLKUS_W(CLKUS_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cfgCountThreshold(cfgCountThreshold), .cfgFilterClocks(cfgFilterClocks),
    .cfgHoldUs(cfgHoldUs), .cfgClocksPerUs(cfgClocksPerUs),
    .status(status), .countValue(countValue)
  );

endmodule

// File: rtl/ocAlarmChecker.sv
module ocAlarmChecker #(
  parameter int COUNT_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               eventPulse,
  input logic               countClear,
  input logic               holdLoad,
  input logic               countReached,
  input logic [COUNT_W-1:0] countValue,
  input logic               irqOut,
  input logic               irqClear,
  input logic               cfgIrqEnable,
  input logic               throttleReq
);

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(cfgIrqEnable));

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !irqClear) |=> irqOut);

  assert_irq_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear && !(eventPulse && countReached && cfgIrqEnable)) |=> !irqOut);

  assert_count_steady_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!eventPulse && !countClear) |=> $stable(countValue));

  assert_filter_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    countClear |=> (countValue == '0));

  assert_event_counts_R4: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |=> (countValue != '0));

  assert_throttle_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(throttleReq) |-> $past(holdLoad));

endmodule

bind ocAlarmMonitor ocAlarmChecker #(.COUNT_W(COUNT_W)) checker_i (
  .clk(clk), .rstN(rstN),
  .eventPulse(strobes.countInc), .countClear(strobes.countClear),
  .holdLoad(strobes.holdLoad), .countReached(status.countReached),
  .countValue(countValue), .irqOut(irqOut), .irqClear(irqClear),
  .cfgIrqEnable(cfgIrqEnable), .throttleReq(throttleReq)
);

// File: tb/ocAlarmMonitor_tb_top.sv
module ocAlarmMonitor_tb_top;

  localparam int CW = 8, FW = 16, HW = 8, PW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          alarmPin = 1'b0;
  logic          cfgActiveLow = 1'b0;
  logic          cfgIrqEnable = 1'b0;
  logic [CW-1:0] cfgCountThreshold = '0;
  logic [FW-1:0] cfgFilterClocks = '0;
  logic [HW-1:0] cfgHoldUs = '0;
  logic [PW-1:0] cfgClocksPerUs = '0;
  logic          irqClear = 1'b0;
  logic          throttleReq, irqOut;

  ocAlarmMonitor #(.COUNT_W(CW), .FILTER_W(FW), .HOLD_W(HW), .CLKUS_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .alarmPin(alarmPin), .cfgActiveLow(cfgActiveLow),
    .cfgIrqEnable(cfgIrqEnable), .cfgCountThreshold(cfgCountThreshold),
    .cfgFilterClocks(cfgFilterClocks), .cfgHoldUs(cfgHoldUs),
    .cfgClocksPerUs(cfgClocksPerUs), .irqClear(irqClear),
    .throttleReq(throttleReq), .irqOut(irqOut)
  );

  int    tests = 0, fails = 0;
  string curReq = "R10";
  bit    done = 1'b0;

  // Reference state, from the requirements: an event is seen on the third edge
  // after the pin change; the throttle follows the same delay plus the hold.
  int t, countM, lastEv, holdEnd;
  bit a0, a1, a2, a3, irqM;

  function automatic int holdClocks();
    return int'(cfgHoldUs) * ((cfgClocksPerUs == 0) ? 1 : int'(cfgClocksPerUs));
  endfunction

  task automatic compareOut(input bit expIrq, input bit expThr);
    tests++;
    if (irqOut !== expIrq || throttleReq !== expThr) begin
      fails++;
      $display("FAIL %s t=%0d irqOut/throttleReq actual=%0b/%0b expected=%0b/%0b",
               curReq, t, irqOut, throttleReq, expIrq, expThr);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; irqClear = 1'b0; alarmPin = cfgActiveLow;
    repeat (2) @(negedge clk);
    t = 0; countM = 0; lastEv = 0; holdEnd = -1; irqM = 1'b0;
    a0 = 0; a1 = 0; a2 = 0; a3 = 0;
    rstN = 1'b1;
  endtask

  task automatic step(input bit act, input bit clr);
    bit ev, setI, thrM;
    alarmPin = act ^ cfgActiveLow;
    irqClear = clr;
    @(posedge clk);
    t++;
    a3 = a2; a2 = a1; a1 = a0; a0 = act;
    @(negedge clk);
    ev = a2 & ~a3;
    setI = 1'b0;
    if (ev) begin
      if (cfgFilterClocks != 0 && countM != 0 && (t - lastEv) > int'(cfgFilterClocks))
        countM = 0;
      if (countM < 255) countM++;
      lastEv = t;
      if (cfgIrqEnable && countM >= int'(cfgCountThreshold)) setI = 1'b1;
    end
    if (setI) irqM = 1'b1;
    else if (clr) irqM = 1'b0;
    if (a2) holdEnd = t + holdClocks();
    thrM = a2 || (t <= holdEnd);
    compareOut(irqM, thrM);
  endtask

  task automatic pulse(input int hi, input int lo);
    for (int i = 0; i < hi; i++) step(1'b1, 1'b0);
    for (int i = 0; i < lo; i++) step(1'b0, 1'b0);
  endtask

  task automatic setCfg(input bit low, input bit en, input int thr, input int flt,
                        input int hus, input int cpu);
    cfgActiveLow = low; cfgIrqEnable = en;
    cfgCountThreshold = CW'(thr); cfgFilterClocks = FW'(flt);
    cfgHoldUs = HW'(hus); cfgClocksPerUs = PW'(cpu);
    doReset();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c11));

    // R10: reset state
    setCfg(0, 1, 0, 0, 0, 1);
    curReq = "R10"; compareOut(1'b0, 1'b0);
    step(1'b0, 1'b0);

    // R2: active-high pulse, throttle latency and level follow
    curReq = "R2"; setCfg(0, 0, 0, 0, 0, 1); pulse(5, 6); pulse(1, 5);
    // R1: active-low polarity
    curReq = "R1"; setCfg(1, 0, 0, 0, 0, 1); pulse(4, 6); pulse(2, 4);

    // R3: hold stretch, including zero clocks per microsecond
    curReq = "R3"; setCfg(0, 0, 0, 0, 2, 3); pulse(3, 15);
    setCfg(1, 0, 0, 0, 3, 0); pulse(2, 10);
    setCfg(0, 0, 0, 0, 1, 1); pulse(1, 6); pulse(2, 1); pulse(1, 8);

    // R4: a long level counts once
    curReq = "R4"; setCfg(0, 1, 2, 0, 0, 1); pulse(12, 5); pulse(1, 5);

    // R5: threshold of three
    curReq = "R5"; setCfg(0, 1, 3, 0, 0, 1); pulse(1, 3); pulse(1, 3); pulse(1, 5);

    // R6: threshold zero, interrupt on each event
    curReq = "R6"; setCfg(1, 1, 0, 0, 0, 1); pulse(1, 4);
    step(1'b0, 1'b1); pulse(0, 2); pulse(1, 5);

    // R7: interrupt disabled
    curReq = "R7"; setCfg(0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 6; i++) pulse(1, 2);

    // R8: inactivity window boundaries with F = 10
    curReq = "R8"; setCfg(0, 1, 2, 10, 0, 1); pulse(1, 12); pulse(1, 4);
    setCfg(0, 1, 2, 10, 0, 1); pulse(1, 9); pulse(1, 4);
    setCfg(0, 1, 2, 10, 0, 1); pulse(1, 8); pulse(1, 4);
    setCfg(0, 1, 2, 10, 0, 1); pulse(1, 10); pulse(1, 4);
    setCfg(0, 1, 2, 0, 0, 1); pulse(1, 40); pulse(1, 4);

    // R9: sticky interrupt, clear, and set winning over clear
    curReq = "R9"; setCfg(0, 1, 0, 0, 0, 1); pulse(1, 6);
    step(1'b0, 1'b1); pulse(0, 3);
    pulse(1, 1); step(1'b0, 1'b1); pulse(0, 3);
    step(1'b0, 1'b1); pulse(0, 2);

    // Random segments mixing all rules
    curReq = "R5/R8/R3 random";
    for (int s = 0; s < 10; s++) begin
      bit cur;
      setCfg($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 5),
             $urandom_range(0, 25), $urandom_range(0, 3), $urandom_range(0, 4));
      cur = 1'b0;
      for (int i = 0; i < 200; i++) begin
        if ($urandom_range(0, 5) == 0) cur = ~cur;
        step(cur, $urandom_range(0, 19) == 0);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule